// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

This block is a register-mapped event timer. A single 64-bit main counter runs from the block clock, and a parameterized set of comparator channels all watch it. Each channel raises an event when the counter reaches the channel's comparator value. A channel runs either one-shot, where it fires once and then waits for a new comparator value, or periodic, where it reloads itself by a fixed period after every event. Only channels built with periodic capability can run periodic. Each channel drives its own interrupt line. In level mode the line follows a sticky bit in a shared status register, and software clears that bit by writing 1 to it. In edge mode the line gives a single-cycle pulse and the status bit is left alone.

Software reaches the block through a simple bus with 32-bit and 64-bit accesses. Reads return data in the same cycle, and writes take effect at the clock edge. A periodic channel holds a period register that has no address of its own. Setting the value-set bit in the channel configuration turns the next two comparator writes into a pair: the first write gives the time of the first event and the second gives the reload period. A channel can be forced to 32-bit comparison, and a channel built without 64-bit capability always compares 32 bits. Each channel's configuration also carries a read-only constant that lists the allowed interrupt lines.

Top module: `mct_timer`

## Requirements
- R1: After reset the main counter, the global enable and the status register read 0, and every comparator reads all ones. Every channel configuration reads with level, interrupt-enable, periodic, value-set and force-32 all 0, and every irq output is 0. Configuration bit layout: bit1 level mode, bit2 interrupt enable, bit3 periodic, bit4 periodic-capable (read-only), bit5 64-bit-capable (read-only), bit6 value-set, bit8 force-32, bits 63:32 route capability (read-only).
- R2: The main counter (offset 0x08) increments by exactly one per clock while global enable (bit0 of offset 0x00) is 1, and holds while it is 0. Writes to the counter take effect only while global enable is 0 and are ignored otherwise.
- R3: Writes to a comparator never change the main counter.
- R4: A channel matches when the main counter, while it is enabled, equals the armed comparator. A one-shot channel then disarms and matches again only after its comparator is written. A comparator write arms the channel.
- R5: A periodic channel adds its period to its comparator in the same cycle as the match, so matches repeat every period ticks. A plain comparator write (value-set not pending) loads both the comparator and the period.
- R6: Writing a configuration with value-set and periodic both 1 on a periodic-capable channel starts a pair sequence. The next low-half comparator write loads the first match time, and the one after it loads the period and arms the channel. The value-set bit reads 1 while the sequence is pending and 0 after it.
- R7: On a channel without periodic capability the periodic and value-set bits always read 0, and the channel behaves one-shot.
- R8: The status register (offset 0x10) has bit n for channel n. A level-mode match sets the bit. Writing 1 to the bit clears it, writing 0 leaves it unchanged, and a set in the same cycle wins over a clear.
- R9: In level mode irq[n] equals status bit n AND interrupt enable. In edge mode irq[n] is a one-cycle pulse, given in the cycle after the match when interrupt enable is 1, and the status bit is not set.
- R10: With force-32 set, or on a channel without 64-bit capability, the match and the periodic addition use only the low 32 bits.
- R11: The route capability field, the periodic-capable bit and the 64-bit-capable bit are read-only. Writes to them leave them unchanged.
- R12: A 64-bit access uses address bits [7:3]. A 32-bit access uses address bit 2 to select the low half (0) or the high half (1) of the addressed register, and read data comes back in bits 31:0 with bits 63:32 zero. Channel n has its configuration at 0x20+16n and its comparator at 0x28+16n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Write strobe for the current access |
| busWide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| busAddr | input | 8 | Byte address of the access |
| busWData | input | 64 | Write data (32-bit accesses use bits 31:0) |
| busRData | output | 64 | Read data for busAddr, combinational |
| irq | output | NUM_CH | Per-channel interrupt outputs |

## Verification
One-shot matches are swept over several comparator values from a cleared counter. On every cycle the bench compares the sampled counter against the expected level of the interrupt line, and reruns without rearming to show the channel stays quiet. Periodic channels run in edge mode through long sweeps, both with the two-write value-set sequence (first time and period different) and with a single plain write (both equal), so the arithmetic pulse pattern tells apart which value landed in which register. Force-32 runs with non-zero upper comparator bits, one with the mode set and one without, so a low-half match and a full-width match predict different outcomes. A non-capable channel runs given periodic settings, and must produce exactly one pulse.

// File: rtl/mct_pkg.sv
package mct_pkg;

  localparam int DATA_W = 64;

  // Channel configuration bit positions
  localparam int CFG_LEVEL = 1;
  localparam int CFG_IEN   = 2;
  localparam int CFG_PER   = 3;
  localparam int CFG_PCAP  = 4;
  localparam int CFG_WCAP  = 5;
  localparam int CFG_VSET  = 6;
  localparam int CFG_F32   = 8;

  // Register map
  localparam logic [7:0] ADDR_GCFG    = 8'h00;
  localparam logic [7:0] ADDR_CNT     = 8'h08;
  localparam logic [7:0] ADDR_STS     = 8'h10;
  localparam logic [7:0] ADDR_CH_BASE = 8'h20;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_GCFG,
    OP_CNT,
    OP_STS,
    OP_CHCFG,
    OP_CHCMP
  } opKind_e;

  typedef struct packed {
    opKind_e            op;
    logic [7:0]         ch;
    logic               lowHalf;
    logic [DATA_W-1:0]  data;
    logic [DATA_W-1:0]  mask;
  } wrStrobe_t;

endpackage

// File: rtl/mct_ctrl.sv
module mct_ctrl
  import mct_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                         busWrEn,
  input  logic                         busWide,
  input  logic [7:0]                   busAddr,
  input  logic [DATA_W-1:0]            busWData,
  input  logic                         gEn,
  input  logic [DATA_W-1:0]            cnt,
  input  logic [NUM_CH-1:0]            sts,
  input  logic [NUM_CH-1:0][DATA_W-1:0] chCfg,
  input  logic [NUM_CH-1:0][DATA_W-1:0] chCmp,
  output wrStrobe_t                    wr,
  output logic [DATA_W-1:0]            busRData
);

  localparam int HALF_W = DATA_W / 2;

  logic [7:0] wordAddr;
  logic [7:0] chOffs;
  logic       hiSel;
  logic       aligned;
  logic       inCh;
  logic [3:0] chIdx;
  logic [DATA_W-1:0] word;

  assign wordAddr = {busAddr[7:3], 3'b000};
  assign hiSel    = !busWide && busAddr[2];
  assign aligned  = (busAddr[1:0] == 2'b00) && (!busWide || !busAddr[2]);
  assign chOffs   = wordAddr - ADDR_CH_BASE;
  assign chIdx    = chOffs[7:4];
  assign inCh     = (wordAddr >= ADDR_CH_BASE) && (32'(chIdx) < NUM_CH);

  // Write strobe formation
  always_comb begin
    wr.op      = OP_NONE;
    wr.ch      = {4'b0000, chIdx};
    wr.lowHalf = !hiSel;
    if (busWide) begin
      wr.data = busWData;
      wr.mask = '1;
    end else if (hiSel) begin
      wr.data = {busWData[HALF_W-1:0], {HALF_W{1'b0}}};
      wr.mask = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
    end else begin
      wr.data = {{HALF_W{1'b0}}, busWData[HALF_W-1:0]};
      wr.mask = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    end
    if (busWrEn && aligned) begin
      if (wordAddr == ADDR_GCFG)      wr.op = OP_GCFG;
      else if (wordAddr == ADDR_CNT)  wr.op = OP_CNT;
      else if (wordAddr == ADDR_STS)  wr.op = OP_STS;
      else if (inCh)                  wr.op = wordAddr[3] ? OP_CHCMP : OP_CHCFG;
    end
  end

  // Read mux
  always_comb begin
    word = '0;
    if (wordAddr == ADDR_GCFG)      word = {{(DATA_W-1){1'b0}}, gEn};
    else if (wordAddr == ADDR_CNT)  word = cnt;
    else if (wordAddr == ADDR_STS)  word = {{(DATA_W-NUM_CH){1'b0}}, sts};
    else begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (inCh && 32'(chIdx) == k) word = wordAddr[3] ? chCmp[k] : chCfg[k];
      end
    end
    if (!aligned)     busRData = '0;
    else if (busWide) busRData = word;
    else if (hiSel)   busRData = {{HALF_W{1'b0}}, word[DATA_W-1:HALF_W]};
    else              busRData = {{HALF_W{1'b0}}, word[HALF_W-1:0]};
  end

endmodule

// File: rtl/mct_channel.sv
module mct_channel
  import mct_pkg::*;
#(
  parameter int          IDX       = 0,
  parameter bit          PER_CAP   = 1'b1,
  parameter bit          WIDE_CAP  = 1'b1,
  parameter logic [31:0] ROUTE_CAP = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         wr,
  input  logic [DATA_W-1:0] cnt,
  input  logic              cntEn,
  output logic              match,
  output logic              levelMode,
  output logic              intEn,
  output logic [DATA_W-1:0] cfgOut,
  output logic [DATA_W-1:0] cmpOut
);

  localparam int HALF_W = DATA_W / 2;

  typedef enum logic [1:0] {VS_IDLE, VS_FIRST, VS_PERIOD} vsState_e;

  logic              periodic;
  logic              force32;
  logic              armed;
  vsState_e          vState;
  logic [DATA_W-1:0] cmp;
  logic [DATA_W-1:0] period;

  logic              myCfg;
  logic              myCmp;
  logic              narrow32;
  logic [DATA_W-1:0] cmpMask;
  logic [DATA_W-1:0] cmpNew;
  logic [DATA_W-1:0] periodNew;
  logic [DATA_W-1:0] cmpStep;
  logic              perReq;

  assign myCfg     = (wr.op == OP_CHCFG) && (wr.ch == 8'(IDX)) && wr.mask[0];
  assign myCmp     = (wr.op == OP_CHCMP) && (wr.ch == 8'(IDX));
  assign narrow32  = force32 || !WIDE_CAP;
  assign cmpMask   = narrow32 ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : '1;
  assign cmpNew    = (cmp & ~wr.mask) | (wr.data & wr.mask);
  assign periodNew = (period & ~wr.mask) | (wr.data & wr.mask);
  assign perReq    = wr.data[CFG_PER] && PER_CAP;
  assign match     = cntEn && armed && (((cnt ^ cmp) & cmpMask) == '0);

  always_comb begin
    if (narrow32) cmpStep = {cmp[DATA_W-1:HALF_W], cmp[HALF_W-1:0] + period[HALF_W-1:0]};
    else          cmpStep = cmp + period;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelMode <= 1'b0;
      intEn     <= 1'b0;
      periodic  <= 1'b0;
      force32   <= 1'b0;
      vState    <= VS_IDLE;
    end else if (myCfg) begin
      levelMode <= wr.data[CFG_LEVEL];
      intEn     <= wr.data[CFG_IEN];
      periodic  <= perReq;
      force32   <= wr.data[CFG_F32];
      vState    <= (perReq && wr.data[CFG_VSET]) ? VS_FIRST : VS_IDLE;
    end else if (myCmp && wr.lowHalf && vState == VS_FIRST) begin
      vState <= VS_PERIOD;
    end else if (myCmp && wr.lowHalf && vState == VS_PERIOD) begin
      vState <= VS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmp    <= '1;
      period <= '0;
      armed  <= 1'b0;
    end else if (myCmp && !wr.lowHalf) begin
      cmp <= cmpNew;
    end else if (myCmp) begin
      case (vState)
        VS_FIRST: begin
          cmp   <= cmpNew;
          armed <= 1'b0;
        end
        VS_PERIOD: begin
          period <= periodNew;
          armed  <= 1'b1;
        end
        default: begin
          cmp   <= cmpNew;
          armed <= 1'b1;
          if (periodic) period <= periodNew;
        end
      endcase
    end else if (match) begin
      if (periodic) cmp   <= cmpStep;
      else          armed <= 1'b0;
    end
  end

  always_comb begin
    cfgOut                = '0;
    cfgOut[63:32]         = ROUTE_CAP;
    cfgOut[CFG_LEVEL]     = levelMode;
    cfgOut[CFG_IEN]       = intEn;
    cfgOut[CFG_PER]       = periodic;
    cfgOut[CFG_PCAP]      = PER_CAP;
    cfgOut[CFG_WCAP]      = WIDE_CAP;
    cfgOut[CFG_VSET]      = (vState != VS_IDLE);
    cfgOut[CFG_F32]       = force32;
  end
  assign cmpOut = cmp;

  // R4: a one-shot match disarms the channel, so no match follows at once
  p_oneshot_disarm_r4: assert property (@(posedge clk) disable iff (!rstN)
    match && !periodic && !myCmp |=> !match);

  // R5: a full-width periodic match advances the comparator by the period
  p_period_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    match && periodic && !myCmp && !narrow32 |=> cmp == $past(cmp) + $past(period));

  // R6: the period write ends the value-set sequence
  p_vset_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    myCmp && wr.lowHalf && vState == VS_PERIOD |=> vState == VS_IDLE);

  // R7: a channel without periodic capability never holds periodic mode
  p_nocap_oneshot_r7: assert property (@(posedge clk) disable iff (!rstN)
    myCfg |=> (periodic == 1'b0) || PER_CAP);

endmodule

// File: rtl/mct_datapath.sv
module mct_datapath
  import mct_pkg::*;
#(
  parameter int                 NUM_CH        = 3,
  parameter logic [NUM_CH-1:0]  PER_CAP_MASK  = '1,
  parameter logic [NUM_CH-1:0]  WIDE_CAP_MASK = '1,
  parameter logic [31:0]        ROUTE_CAP     = 32'h0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wrStrobe_t                     wr,
  output logic                          gEn,
  output logic [DATA_W-1:0]             cnt,
  output logic [NUM_CH-1:0]             sts,
  output logic [NUM_CH-1:0][DATA_W-1:0] chCfg,
  output logic [NUM_CH-1:0][DATA_W-1:0] chCmp,
  output logic [NUM_CH-1:0]             irq
);

  logic [NUM_CH-1:0] match;
  logic [NUM_CH-1:0] level;
  logic [NUM_CH-1:0] ien;
  logic [NUM_CH-1:0] edgeQ;

  // Main counter and global enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gEn <= 1'b0;
      cnt <= '0;
    end else begin
      if (wr.op == OP_GCFG && wr.mask[0]) gEn <= wr.data[0];
      if (gEn)                      cnt <= cnt + 1'b1;
      else if (wr.op == OP_CNT)     cnt <= (cnt & ~wr.mask) | (wr.data & wr.mask);
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    mct_channel #(
      .IDX       (i),
      .PER_CAP   (PER_CAP_MASK[i]),
      .WIDE_CAP  (WIDE_CAP_MASK[i]),
      .ROUTE_CAP (ROUTE_CAP)
    ) u_ch (
      .clk       (clk),
      .rstN      (rstN),
      .wr        (wr),
      .cnt       (cnt),
      .cntEn     (gEn),
      .match     (match[i]),
      .levelMode (level[i]),
      .intEn     (ien[i]),
      .cfgOut    (chCfg[i]),
      .cmpOut    (chCmp[i])
    );

    logic stsClr;
    assign stsClr = (wr.op == OP_STS) && wr.mask[i] && wr.data[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sts[i]   <= 1'b0;
        edgeQ[i] <= 1'b0;
      end else begin
        if (match[i] && level[i]) sts[i] <= 1'b1;
        else if (stsClr)          sts[i] <= 1'b0;
        edgeQ[i] <= match[i] && !level[i] && ien[i];
      end
    end

    assign irq[i] = level[i] ? (sts[i] && ien[i]) : edgeQ[i];

    // R8: write-one clears the status bit when no match sets it
    p_sts_w1c_r8: assert property (@(posedge clk) disable iff (!rstN)
      stsClr && !match[i] |=> !sts[i]);

    // R9: an edge-mode match leaves the status bit unchanged
    p_edge_nosts_r9: assert property (@(posedge clk) disable iff (!rstN)
      match[i] && !level[i] && wr.op != OP_STS |=> $stable(sts[i]));
  end

  // R2: a stopped counter holds unless written
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !gEn && wr.op != OP_CNT |=> $stable(cnt));

  // R3: a running counter steps by one whatever is written elsewhere
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    gEn |=> cnt == $past(cnt) + 64'd1);

endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter int                 NUM_CH        = 3,
  parameter logic [NUM_CH-1:0]  PER_CAP_MASK  = 3'b011,
  parameter logic [NUM_CH-1:0]  WIDE_CAP_MASK = 3'b011,
  parameter logic [31:0]        ROUTE_CAP     = 32'h00F0_0A00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busWide,
  input  logic [7:0]        busAddr,
  input  logic [63:0]       busWData,
  output logic [63:0]       busRData,
  output logic [NUM_CH-1:0] irq
);

  wrStrobe_t                     wr;
  logic                          gEn;
  logic [DATA_W-1:0]             cnt;
  logic [NUM_CH-1:0]             sts;
  logic [NUM_CH-1:0][DATA_W-1:0] chCfg;
  logic [NUM_CH-1:0][DATA_W-1:0] chCmp;

  mct_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .busWrEn  (busWrEn),
    .busWide  (busWide),
    .busAddr  (busAddr),
    .busWData (busWData),
    .gEn      (gEn),
    .cnt      (cnt),
    .sts      (sts),
    .chCfg    (chCfg),
    .chCmp    (chCmp),
    .wr       (wr),
    .busRData (busRData)
  );

  mct_datapath #(
    .NUM_CH        (NUM_CH),
    .PER_CAP_MASK  (PER_CAP_MASK),
    .WIDE_CAP_MASK (WIDE_CAP_MASK),
    .ROUTE_CAP     (ROUTE_CAP)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .wr    (wr),
    .gEn   (gEn),
    .cnt   (cnt),
    .sts   (sts),
    .chCfg (chCfg),
    .chCmp (chCmp),
    .irq   (irq)
  );

endmodule

// File: tb/tb_mct_timer.sv
module tb_mct_timer;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 3;
  localparam logic [63:0] ROUTE = 64'h00F0_0A00_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic busWide = 1'b1;
  logic [7:0] busAddr = '0;
  logic [63:0] busWData = '0;
  logic [63:0] busRData;
  logic [NUM_CH-1:0] irq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mct_timer dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWide(busWide),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData), .irq(irq)
  );

  function automatic logic [7:0] cfgA(int n); return 8'(8'h20 + 16*n); endfunction
  function automatic logic [7:0] cmpA(int n); return 8'(8'h28 + 16*n); endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrAcc(logic wide, logic [7:0] a, logic [63:0] d);
    @(negedge clk);
    busWide = wide; busAddr = a; busWData = d; busWrEn = 1'b1;
    @(posedge clk);
    #1 busWrEn = 1'b0;
  endtask

  task automatic wr64(logic [7:0] a, logic [63:0] d); wrAcc(1'b1, a, d); endtask
  task automatic wr32(logic [7:0] a, logic [31:0] d); wrAcc(1'b0, a, {32'h0, d}); endtask

  task automatic rdAcc(logic wide, logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    busWide = wide; busAddr = a; busWrEn = 1'b0;
    #1 d = busRData;
  endtask

  task automatic rd64(logic [7:0] a, output logic [63:0] d); rdAcc(1'b1, a, d); endtask

  // Stop counter, preset it, clear all status bits
  task automatic prep(logic [63:0] start);
    wr64(8'h00, 64'h0);
    wr64(8'h08, start);
    wr64(8'h10, 64'h7);
  endtask

  logic [63:0] v, v2, r;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd64(8'h00, r); chk("R1 gen enable", r, 64'h0);
    rd64(8'h08, r); chk("R1 counter", r, 64'h0);
    rd64(8'h10, r); chk("R1 status", r, 64'h0);
    rd64(cfgA(0), r); chk("R1 cfg ch0", r, ROUTE | 64'h30);
    rd64(cfgA(1), r); chk("R1 cfg ch1", r, ROUTE | 64'h30);
    rd64(cfgA(2), r); chk("R1 cfg ch2", r, ROUTE);
    for (int n = 0; n < NUM_CH; n++) begin
      rd64(cmpA(n), r); chk("R1 comparator", r, '1);
    end
    chk("R1 irq", 64'(irq), 64'h0);

    // R2 counter write when stopped, hold, count, ignore write when running
    wr64(8'h08, 64'd100);
    rd64(8'h08, r); chk("R2 preset", r, 64'd100);
    repeat (5) @(posedge clk);
    rd64(8'h08, r); chk("R2 hold", r, 64'd100);
    wr64(8'h00, 64'h1);
    rd64(8'h08, v);
    for (int k = 0; k < 10; k++) rd64(8'h08, v2);
    chk("R2 step per clock", v2 - v, 64'd10);
    rd64(8'h08, v);
    wr64(8'h08, 64'h0);
    rd64(8'h08, v2); chk("R2 write ignored while running", v2, v + 2);
    // R3 comparator write leaves the counter alone
    rd64(8'h08, v);
    wr64(cmpA(1), 64'h1234);
    rd64(8'h08, v2); chk("R3 counter untouched", v2, v + 2);

    // R4 / R9 level one-shot sweep on ch0, ch1 level without enable
    for (int ci = 0; ci < 3; ci++) begin
      logic [63:0] c;
      c = (ci == 0) ? 64'd3 : (ci == 1) ? 64'd7 : 64'd12;
      prep(64'h0);
      wr64(cfgA(0), 64'h06);
      wr64(cfgA(1), 64'h02);
      wr64(cmpA(0), c);
      wr64(cmpA(1), c);
      wr64(8'h00, 64'h1);
      for (int k = 0; k < 20; k++) begin
        rd64(8'h08, v);
        chk("R4 one-shot level irq", 64'(irq[0]), 64'(v > c));
        chk("R9 level without enable", 64'(irq[1]), 64'h0);
      end
      rd64(8'h10, r); chk("R9 status set both", r & 64'h3, 64'h3);
    end
    // R8 write zero keeps, write one clears
    wr64(8'h10, 64'h0);
    rd64(8'h10, r); chk("R8 write 0 keeps", r & 64'h3, 64'h3);
    wr64(8'h10, 64'h1);
    rd64(8'h10, r); chk("R8 write 1 clears bit0 only", r & 64'h3, 64'h2);
    // R4 no rematch without rewrite
    prep(64'h0);
    wr64(8'h00, 64'h1);
    for (int k = 0; k < 20; k++) begin
      rd64(8'h08, v);
      chk("R4 disarmed stays quiet", 64'(irq[0]), 64'h0);
    end
    prep(64'h0);
    wr64(cmpA(0), 64'd5);
    wr64(8'h00, 64'h1);
    for (int k = 0; k < 12; k++) begin
      rd64(8'h08, v);
      chk("R4 rearmed by write", 64'(irq[0]), 64'(v > 5));
    end

    // R6 / R5 value-set pair on ch1, edge mode
    prep(64'h0);
    wr64(cfgA(1), 64'h4C);
    rd64(cfgA(1), r); chk("R6 value-set pending", r, ROUTE | 64'h7C);
    wr64(cmpA(1), 64'd5);
    wr64(cmpA(1), 64'd3);
    rd64(cfgA(1), r); chk("R6 value-set cleared", r, ROUTE | 64'h3C);
    rd64(cmpA(1), r); chk("R6 first time in comparator", r, 64'd5);
    wr64(8'h00, 64'h1);
    for (int k = 0; k < 40; k++) begin
      rd64(8'h08, v);
      chk("R5 periodic pulses", 64'(irq[1]),
          64'((v > 5) && (((v - 1 - 5) % 3) == 0)));
    end
    wr64(8'h00, 64'h0);
    rd64(8'h08, v);
    begin
      logic [63:0] nxt;
      nxt = 5;
      while (nxt <= v - 1) nxt += 3;
      rd64(cmpA(1), r); chk("R5 comparator advanced", r, nxt);
    end
    rd64(8'h10, r); chk("R9 edge leaves status", r & 64'h2, 64'h0);

    // R5 plain write sets comparator and period together, ch0
    prep(64'h0);
    wr64(cfgA(0), 64'h0C);
    wr64(cmpA(0), 64'd4);
    wr64(8'h00, 64'h1);
    for (int k = 0; k < 30; k++) begin
      rd64(8'h08, v);
      chk("R5 single write period", 64'(irq[0]),
          64'((v > 4) && (((v - 1) % 4) == 0)));
    end

    // R7 non-capable channel stays one-shot
    prep(64'h0);
    wr64(cfgA(2), 64'h4C);
    rd64(cfgA(2), r); chk("R7 periodic bits read 0", r, ROUTE | 64'h04);
    wr64(cmpA(2), 64'd6);
    wr64(8'h00, 64'h1);
    for (int k = 0; k < 30; k++) begin
      rd64(8'h08, v);
      chk("R7 single pulse", 64'(irq[2]), 64'(v == 7));
    end

    // R10 force-32 compare on low half
    for (int m = 0; m < 2; m++) begin
      prep(64'h5_0000_0008);
      wr64(cfgA(0), (m == 0) ? 64'h106 : 64'h006);
      wr64(cmpA(0), 64'hFFFF_FFFF_0000_0010);
      wr64(8'h00, 64'h1);
      for (int k = 0; k < 20; k++) begin
        rd64(8'h08, v);
        chk("R10 force-32 match", 64'(irq[0]),
            (m == 0) ? 64'(v > 64'h5_0000_0010) : 64'h0);
      end
    end
    prep(64'h5_0000_0008);
    wr64(cfgA(2), 64'h006);
    wr64(cmpA(2), 64'hABCD_0000_0000_0012);
    wr64(8'h00, 64'h1);
    for (int k = 0; k < 20; k++) begin
      rd64(8'h08, v);
      chk("R10 narrow channel match", 64'(irq[2]), 64'(v > 64'h5_0000_0012));
    end

    // R12 32-bit accesses
    wr64(8'h00, 64'h0);
    wr32(8'h08, 32'h1234_5678);
    wr32(8'h0C, 32'h0000_0009);
    rd64(8'h08, r); chk("R12 halves merged", r, 64'h9_1234_5678);
    rdAcc(1'b0, 8'h0C, r); chk("R12 high half read", r, 64'h9);
    rdAcc(1'b0, 8'h08, r); chk("R12 low half read", r, 64'h1234_5678);

    // R11 read-only fields
    wr64(cfgA(1), 64'hFFFF_FFFF_0000_0000);
    rd64(cfgA(1), r); chk("R11 route and caps read-only", r, ROUTE | 64'h30);
    rdAcc(1'b0, 8'h34, r); chk("R11 route via high half", r, 64'h00F0_0A00);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule